// File: doc/BRIEF.md
# Dual-Width Pixel Word Packer

This block collects display pixel data arriving on a 12-pin parallel bus and packs it into 24-bit words for an internal data bus. A width select chooses the input width, either 8 or 12 bits per beat. At 8 bits a word takes three beats, and at 12 bits it takes two. A beat is taken on each falling edge of a data clock pin. The data clock is oversampled by the block's own system clock, and a beat is taken only while the chip-select enable is high. The first beat of a word lands in the most significant bits of the word.

When a word is complete, the block presents it on `word_out` together with a single-cycle `word_vld` strobe. It also counts delivered words toward a line of ten words (240 bits). When the tenth word is delivered it raises `line_done` and takes no further beats. A line-latch pulse clears the partial word, the word count and `line_done`, and it is the only point at which the width select is read.

The word output is a plain strobe with no back-pressure: there is no ready input. The consumer must accept a word in the cycle `word_vld` is high. After that, `word_out` keeps the word until the next one replaces it.

Top module: `pxpk_top`

## Requirements
- R1: After reset, `word_vld` and `line_done` are 0 and `word_out` is 0. The latched width is 8-bit, so three beats complete a word before any line-latch pulse.
- R2: `width_sel` read as 0 selects 8-bit beats on `din[7:0]`, with three beats per word. `width_sel` read as 1 selects 12-bit beats on `din[11:0]`, with two beats per word.
- R3: A beat is taken once per falling edge of `dclk`. A falling edge is a system-clock sample of 0 that follows a sample of 1. Holding `dclk` low takes no further beats.
- R4: The first beat of a word occupies the most significant bits of `word_out`, and each later beat sits directly below the one before it.
- R5: `word_vld` is high for exactly one cycle, the cycle after the system-clock edge that takes the completing beat. `word_out` changes only in that cycle and otherwise holds its value.
- R6: In 8-bit mode the levels on `din[11:8]` have no effect on `word_out`.
- R7: A falling edge of `dclk` while `cs_en` is 0 is ignored, and any partly assembled word is kept.
- R8: A cycle with `lp` high clears the partial word, the word count and `line_done`, and latches `width_sel`. A change of `width_sel` between pulses has no effect. A falling edge in the same cycle as `lp` is not taken.
- R9: `line_done` rises in the same cycle as the `word_vld` of the tenth word of a line and stays high until `lp`. While it is high, no beats are taken and no words are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dclk | input | 1 | Data clock pin; beats are taken on its falling edge |
| cs_en | input | 1 | Chip-select enable; beats are taken only while it is high |
| lp | input | 1 | Line-latch pulse; clears the counters and latches the width |
| width_sel | input | 1 | Width select: 0 = 8-bit, 1 = 12-bit |
| din | input | 12 | Parallel pixel data pins |
| word_out | output | 24 | Last completed 24-bit word |
| word_vld | output | 1 | One-cycle strobe for a new word |
| line_done | output | 1 | Ten words delivered since the last line-latch pulse |

## Verification
A `dclk` fall driven before a system-clock edge is taken at that edge. The resulting `word_vld`, `word_out` and `line_done` are visible from that edge, so the bench reads them at the falling clock edge right after it. `word_vld` is low again one edge later, and the bench confirms this with a dedicated check one cycle after each word. `lp` acts at the edge where it is high. Ignored stimuli (a beat with `cs_en` low, `dclk` held low, a beat after `line_done`, a beat in the same cycle as `lp`) are judged at the same post-edge sample and again through the contents of the next completed word.

// File: rtl/pxpk_pkg.sv
package pxpk_pkg;
  typedef enum logic {
    W_NARROW = 1'b0,
    W_WIDE   = 1'b1
  } width_e;
endpackage

// File: rtl/pxpk_fall_det.sv
module pxpk_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic dclk,
  output logic fall
);
  logic dclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dclk_q <= 1'b0;
    else        dclk_q <= dclk;
  end

  assign fall = dclk_q & ~dclk;

  // two falls can never be adjacent: the previous sample must be high again first
  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall) else $error("fall seen on two cycles in a row"); // R3
endmodule

// File: rtl/pxpk_assembler.sv
module pxpk_assembler
  import pxpk_pkg::*;
#(
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 12,
  parameter int WORD_W   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lp,
  input  logic              width_sel,
  input  logic              take,
  input  logic [WIDE_W-1:0] din,
  output logic              word_fire,
  output logic              word_vld,
  output logic [WORD_W-1:0] word_out
);
  localparam int NARROW_BEATS = WORD_W / NARROW_W;
  localparam int WIDE_BEATS   = WORD_W / WIDE_W;
  localparam int BEAT_CW      = $clog2(NARROW_BEATS + 1);
  localparam int ACC_W        = WORD_W - NARROW_W;

  width_e             width_q;
  logic [BEAT_CW-1:0] beat_cnt;
  logic [BEAT_CW-1:0] beats_need;
  logic [ACC_W-1:0]   acc;
  logic [WORD_W-1:0]  next_word;
  logic               last_beat;

  assign beats_need = (width_q == W_WIDE) ? BEAT_CW'(WIDE_BEATS) : BEAT_CW'(NARROW_BEATS);
  assign last_beat  = (beat_cnt == beats_need - BEAT_CW'(1));
  assign word_fire  = take & last_beat;

  // earlier beats shift up, the new beat enters at the bottom
  always_comb begin
    if (width_q == W_WIDE)
      next_word = {acc[WORD_W-WIDE_W-1:0], din};
    else
      next_word = {acc, din[NARROW_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q  <= W_NARROW;
      beat_cnt <= '0;
      acc      <= '0;
      word_out <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (lp) begin
        width_q  <= width_e'(width_sel);
        beat_cnt <= '0;
        acc      <= '0;
      end else if (take) begin
        acc <= next_word[ACC_W-1:0];
        if (last_beat) begin
          beat_cnt <= '0;
          word_out <= next_word;
          word_vld <= 1'b1;
        end else begin
          beat_cnt <= beat_cnt + BEAT_CW'(1);
        end
      end
    end
  end

  AST_BEAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    beat_cnt < beats_need) else $error("beat count past word length"); // R2
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld) else $error("word strobe longer than one cycle"); // R5
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |-> $stable(word_out)) else $error("word changed without strobe"); // R5
  AST_LP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    lp |=> (beat_cnt == '0) && !word_vld) else $error("line pulse did not restart"); // R8
endmodule

// File: rtl/pxpk_line_count.sv
module pxpk_line_count #(
  parameter int LINE_WORDS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lp,
  input  logic word_fire,
  output logic line_done
);
  localparam int CNT_W = $clog2(LINE_WORDS + 1);

  logic [CNT_W-1:0] word_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_cnt  <= '0;
      line_done <= 1'b0;
    end else if (lp) begin
      word_cnt  <= '0;
      line_done <= 1'b0;
    end else if (word_fire) begin
      word_cnt <= word_cnt + CNT_W'(1);
      if (word_cnt == CNT_W'(LINE_WORDS - 1)) line_done <= 1'b1;
    end
  end

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (line_done && !lp) |=> line_done) else $error("line_done dropped without lp"); // R9
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    word_cnt <= CNT_W'(LINE_WORDS)) else $error("word count past line length"); // R9
  AST_LP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    lp |=> !line_done && (word_cnt == '0)) else $error("lp did not clear count"); // R8
endmodule

// File: rtl/pxpk_top.sv
module pxpk_top #(
  parameter int NARROW_W   = 8,
  parameter int WIDE_W     = 12,
  parameter int WORD_W     = 24,
  parameter int LINE_WORDS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dclk,
  input  logic              cs_en,
  input  logic              lp,
  input  logic              width_sel,
  input  logic [WIDE_W-1:0] din,
  output logic [WORD_W-1:0] word_out,
  output logic              word_vld,
  output logic              line_done
);
  logic fall;
  logic take;
  logic word_fire;

  pxpk_fall_det u_fall (
    .clk   (clk),
    .rst_n (rst_n),
    .dclk  (dclk),
    .fall  (fall)
  );

  // a beat counts only while selected, outside a line pulse, and before the line fills
  assign take = fall & cs_en & ~lp & ~line_done;

  pxpk_assembler #(
    .NARROW_W (NARROW_W),
    .WIDE_W   (WIDE_W),
    .WORD_W   (WORD_W)
  ) u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .lp        (lp),
    .width_sel (width_sel),
    .take      (take),
    .din       (din),
    .word_fire (word_fire),
    .word_vld  (word_vld),
    .word_out  (word_out)
  );

  pxpk_line_count #(
    .LINE_WORDS (LINE_WORDS)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .lp        (lp),
    .word_fire (word_fire),
    .line_done (line_done)
  );

  AST_NO_WORD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_done && !lp) |=> !word_vld) else $error("word after line end"); // R9
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_en |=> !word_vld) else $error("word produced while deselected"); // R7
endmodule

// File: tb/pxpk_top_bench.sv
module pxpk_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dclk = 1'b0;
  logic        cs_en = 1'b1;
  logic        lp = 1'b0;
  logic        width_sel = 1'b0;
  logic [11:0] din = '0;
  logic [23:0] word_out;
  logic        word_vld;
  logic        line_done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pxpk_top u_pxpk_top (
    .clk(clk), .rst_n(rst_n), .dclk(dclk), .cs_en(cs_en), .lp(lp),
    .width_sel(width_sel), .din(din), .word_out(word_out),
    .word_vld(word_vld), .line_done(line_done)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one beat: dclk high for a cycle, then low with data; returns after the taking edge
  task automatic beat(input logic [11:0] d, input logic en);
    @(negedge clk) dclk = 1'b1;
    @(negedge clk) begin dclk = 1'b0; din = d; cs_en = en; end
    @(negedge clk) cs_en = 1'b1;
  endtask

  task automatic line_pulse(input logic m);
    @(negedge clk) begin lp = 1'b1; width_sel = m; end
    @(negedge clk) lp = 1'b0;
  endtask

  function automatic logic [11:0] pix(input int s, input int w, input int b);
    return 12'((s * 37 + w * 11 + b * 5 + 3) * 29);
  endfunction

  initial begin
    logic [23:0] exp;
    logic [23:0] held;
    int nb;
    int bw;
    repeat (3) @(negedge clk);
    check("R1 vld after reset", 32'(word_vld), 0);
    check("R1 done after reset", 32'(line_done), 0);
    check("R1 word after reset", 32'(word_out), 0);
    rst_n = 1'b1;

    // R1: default width is 8-bit, three beats complete a word
    beat(12'hF12, 1'b1); check("R1 no word after beat 1", 32'(word_vld), 0);
    beat(12'hE34, 1'b1); check("R1 no word after beat 2", 32'(word_vld), 0);
    beat(12'hD56, 1'b1);
    check("R1 word after beat 3", 32'(word_vld), 1);
    check("R1 default word", 32'(word_out), 32'h123456);

    // main sweep: both widths, several data seeds, full lines
    for (int m = 0; m < 2; m++) begin
      nb = (m == 1) ? 2 : 3;
      bw = (m == 1) ? 12 : 8;
      for (int s = 0; s < 3; s++) begin
        line_pulse(m[0]);
        check("R8 done cleared by lp", 32'(line_done), 0);
        for (int w = 0; w < 10; w++) begin
          exp = '0;
          for (int b = 0; b < nb; b++) begin
            // R6: in 8-bit mode upper pins carry junk
            beat(pix(s, w, b), 1'b1);
            exp = (exp << bw) | 24'(pix(s, w, b) & ((m == 1) ? 12'hFFF : 12'h0FF));
            check("R2 strobe on last beat only", 32'(word_vld), (b == nb - 1) ? 1 : 0);
          end
          check((m == 1) ? "R4 wide word packing" : "R6 narrow word ignores upper pins",
                32'(word_out), 32'(exp));
          check("R9 done on tenth word", 32'(line_done), (w == 9) ? 1 : 0);
          @(negedge clk);
          check("R5 strobe one cycle", 32'(word_vld), 0);
          check("R5 word held", 32'(word_out), 32'(exp));
        end
        held = word_out;
        beat(12'hABC, 1'b1);
        beat(12'h123, 1'b1);
        beat(12'h456, 1'b1);
        check("R9 no word after done", 32'(word_vld), 0);
        check("R9 word unchanged after done", 32'(word_out), 32'(held));
        check("R9 done sticky", 32'(line_done), 1);
      end
    end

    // R7: deselected beat ignored, partial word kept
    line_pulse(1'b1);
    beat(12'hA5A, 1'b1);
    beat(12'h777, 1'b0);
    check("R7 no word while deselected", 32'(word_vld), 0);
    beat(12'h3C3, 1'b1);
    check("R7 word skips deselected beat", 32'(word_out), 32'hA5A3C3);

    // R3: holding dclk low takes no further beats
    line_pulse(1'b1);
    beat(12'h111, 1'b1);
    for (int k = 0; k < 4; k++) @(negedge clk) din = 12'(k * 300 + 7);
    check("R3 held low no word", 32'(word_vld), 0);
    beat(12'h222, 1'b1);
    check("R3 one beat per fall", 32'(word_out), 32'h111222);

    // R8: lp drops a partial word; width_sel change without lp ignored
    line_pulse(1'b0);
    beat(12'h0EE, 1'b1);
    line_pulse(1'b1);
    @(negedge clk) width_sel = 1'b0;
    beat(12'h864, 1'b1);
    beat(12'h209, 1'b1);
    check("R8 width held at lp value", 32'(word_vld), 1);
    check("R8 partial word dropped", 32'(word_out), 32'h864209);

    // R8: fall in the same cycle as lp is not taken
    @(negedge clk) dclk = 1'b1;
    @(negedge clk) begin dclk = 1'b0; din = 12'hFFF; lp = 1'b1; width_sel = 1'b1; end
    @(negedge clk) lp = 1'b0;
    check("R8 no word at lp beat", 32'(word_vld), 0);
    beat(12'h135, 1'b1);
    beat(12'h79B, 1'b1);
    check("R8 beat with lp not taken", 32'(word_out), 32'h13579B);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule